// File: doc/BRIEF.md
# Raster Bitmap Shrink Operator

This block erodes a single-layer black/white bitmap that arrives one pixel per valid beat in raster order (row by row, left to right). In each shrink pass a black pixel stays black only when the pixel to its left, the pixel above it and the pixel diagonally above-left are also black. Otherwise it turns white. Up to seven passes can be chained. Each pass works on the output of the pass before it. As a result, a width rule longer than a short-rule checker can handle is checked on a thinned copy of the layer.

The number of passes is captured on the first pixel of each frame and travels with the pixels. A new count can therefore be set for the next frame while the current one drains. The pipeline always has the depth of the largest pass count, so the output stream keeps the timing of the input stream whatever count is in use. A combinational output gives the reduced rule length to program into the checker, together with a flag that says whether that length lies within the checker's native range.

Top module: `raster_shrink`

## Requirements
- R1: In an active pass, an output pixel is black (1) only when the pixel itself and its left, upper and upper-left neighbours in that pass's input are all black. A pass never turns a white (0) pixel black.
- R2: Neighbours outside the frame count as white. After at least one pass, every pixel in row 0 and column 0 of the frame is white.
- R3: A pass count of n (0 to 7) applies n successive passes, and each pass erodes the result of the previous one.
- R4: A pass count of 0 returns every pixel unchanged.
- R5: `out_valid` equals `in_valid` delayed by exactly MAX_PASS clock cycles (7 by default), whatever the pass count. Idle cycles in the input appear unchanged in the output, and exactly IMG_W*IMG_H valid pixels come out per frame.
- R6: The pass count is sampled on the valid beat of the frame's first pixel (row 0, column 0). Changes to `pass_cnt` later in the frame have no effect on that frame.
- R7: `adj_rule` equals `rule_len` when `pass_cnt` is 0. Otherwise it equals `rule_len - 1 - pass_cnt`, saturating at 0. It follows the inputs combinationally.
- R8: `rule_fits` is 1 exactly when `adj_rule` is between 1 and CHK_MAX (4) inclusive.
- R9: While reset is asserted, and on every cycle without a valid output, both `out_valid` and `out_pix` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pass_cnt | input | 3 | Number of shrink passes, sampled at frame start |
| rule_len | input | RULE_W (4) | Required rule length in pixel units |
| in_valid | input | 1 | Input pixel valid |
| in_pix | input | 1 | Input pixel, 1 = black |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 1 | Shrunk pixel, 1 = black |
| adj_rule | output | RULE_W (4) | Rule length for the checker after shrinking |
| rule_fits | output | 1 | Adjusted rule is within 1..CHK_MAX |

## Verification
Random frames with mostly black pixels are run at every pass count from 0 to 7. Each result is compared with a direct two-dimensional erosion of the whole frame, which separates a correct iteration from a wrong neighbour choice or from passes that fail to chain. An all-black frame shows the exact staircase of the frame-edge rule, and an all-white frame must stay white. A frame with random idle beats confirms that gaps neither shift positions nor change timing. A frame whose pass count changes after its first pixel shows that the count is held for the frame, and a table of rule and count pairs covers saturation and the range flag.

// File: rtl/raster_shrink_pkg.sv
package raster_shrink_pkg;

  localparam int SHR_PASS_W = 3;

  // pixel token carried down the pass pipeline
  typedef struct packed {
    logic                  vld;
    logic                  pix;
    logic                  top_edge;
    logic                  left_edge;
    logic [SHR_PASS_W-1:0] npass;
  } shr_tok_t;

  // one-sided erosion of a single pixel
  function automatic logic erode_px(input logic cur, input logic lft,
                                    input logic up, input logic upl,
                                    input logic top_edge, input logic left_edge);
    return cur & lft & up & upl & ~top_edge & ~left_edge;
  endfunction

  // rule length remaining after x passes, saturating at zero
  function automatic int adjusted_rule(input int m, input int x);
    if (x == 0) return m;
    if (m < x + 1) return 0;
    return m - 1 - x;
  endfunction

endpackage

// File: rtl/raster_pos.sv
module raster_pos
  import raster_shrink_pkg::*;
#(
  parameter int IMG_W = 16,
  parameter int IMG_H = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_pix,
  input  logic [SHR_PASS_W-1:0] pass_cnt,
  output shr_tok_t              tok
);
  localparam int COL_W = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam int ROW_W = (IMG_H > 1) ? $clog2(IMG_H) : 1;
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(IMG_W - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(IMG_H - 1);

  logic [COL_W-1:0]      col_q;
  logic [ROW_W-1:0]      row_q;
  logic [SHR_PASS_W-1:0] npass_hold;
  logic                  frame_start;

  assign frame_start = (col_q == '0) && (row_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q      <= '0;
      row_q      <= '0;
      npass_hold <= '0;
    end else if (in_valid) begin
      if (frame_start) npass_hold <= pass_cnt;
      if (col_q == COL_LAST) begin
        col_q <= '0;
        row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  always_comb begin
    tok.vld       = in_valid;
    tok.pix       = in_pix;
    tok.top_edge  = (row_q == '0);
    tok.left_edge = (col_q == '0);
    tok.npass     = frame_start ? pass_cnt : npass_hold;
  end
endmodule

// File: rtl/shrink_stage.sv
module shrink_stage
  import raster_shrink_pkg::*;
#(
  parameter int IMG_W = 16,
  parameter int IDX   = 0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  shr_tok_t tin,
  output shr_tok_t tout
);
  // hist[k] holds the pixel that arrived k+1 valid beats ago
  logic [IMG_W:0] hist;
  logic           active;
  logic           eroded;

  assign active = int'(tin.npass) > IDX;
  assign eroded = erode_px(tin.pix, hist[0], hist[IMG_W-1], hist[IMG_W],
                           tin.top_edge, tin.left_edge);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
      tout <= '0;
    end else begin
      if (tin.vld) hist <= {hist[IMG_W-1:0], tin.pix};
      tout.vld       <= tin.vld;
      tout.pix       <= tin.vld & (active ? eroded : tin.pix);
      tout.top_edge  <= tin.top_edge;
      tout.left_edge <= tin.left_edge;
      tout.npass     <= tin.npass;
    end
  end
endmodule

// File: rtl/raster_shrink.sv
module raster_shrink
  import raster_shrink_pkg::*;
#(
  parameter int IMG_W    = 16,
  parameter int IMG_H    = 12,
  parameter int MAX_PASS = 7,
  parameter int RULE_W   = 4,
  parameter int CHK_MAX  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SHR_PASS_W-1:0] pass_cnt,
  input  logic [RULE_W-1:0]     rule_len,
  input  logic                  in_valid,
  input  logic                  in_pix,
  output logic                  out_valid,
  output logic                  out_pix,
  output logic [RULE_W-1:0]     adj_rule,
  output logic                  rule_fits
);
  shr_tok_t tok [0:MAX_PASS];

  raster_pos #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_pix   (in_pix),
    .pass_cnt (pass_cnt),
    .tok      (tok[0])
  );

  for (genvar g = 0; g < MAX_PASS; g++) begin : g_pass
    shrink_stage #(.IMG_W(IMG_W), .IDX(g)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .tin   (tok[g]),
      .tout  (tok[g+1])
    );
  end

  // named views of the last token for the checker
  logic                  out_first_row;
  logic                  out_first_col;
  logic [SHR_PASS_W-1:0] out_npass;

  assign out_first_row = tok[MAX_PASS].top_edge;
  assign out_first_col = tok[MAX_PASS].left_edge;
  assign out_npass     = tok[MAX_PASS].npass;
  assign out_valid     = tok[MAX_PASS].vld;
  assign out_pix       = tok[MAX_PASS].vld & tok[MAX_PASS].pix;

  assign adj_rule  = RULE_W'(adjusted_rule(int'(rule_len), int'(pass_cnt)));
  assign rule_fits = (adj_rule != '0) && (int'(adj_rule) <= CHK_MAX);
endmodule

// File: rtl/raster_shrink_chk.sv
module raster_shrink_chk
  import raster_shrink_pkg::*;
#(
  parameter int MAX_PASS = 7,
  parameter int RULE_W   = 4,
  parameter int CHK_MAX  = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [SHR_PASS_W-1:0] pass_cnt,
  input logic [RULE_W-1:0]     rule_len,
  input logic                  in_valid,
  input logic                  in_pix,
  input logic                  out_valid,
  input logic                  out_pix,
  input logic [RULE_W-1:0]     adj_rule,
  input logic                  rule_fits,
  input logic                  out_first_row,
  input logic                  out_first_col,
  input logic [SHR_PASS_W-1:0] out_npass
);
  logic [MAX_PASS-1:0]   dly_v;
  logic [MAX_PASS-1:0]   dly_p;
  int                    fill;
  logic                  seen;
  logic [SHR_PASS_W-1:0] last_np;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly_v   <= '0;
      dly_p   <= '0;
      fill    <= 0;
      seen    <= 1'b0;
      last_np <= '0;
    end else begin
      dly_v <= {dly_v[MAX_PASS-2:0], in_valid};
      dly_p <= {dly_p[MAX_PASS-2:0], in_pix};
      if (fill < MAX_PASS) fill <= fill + 1;
      if (out_valid) begin
        seen    <= 1'b1;
        last_np <= out_npass;
      end
    end
  end

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (fill >= MAX_PASS) |-> (out_valid == dly_v[MAX_PASS-1])); // R5
  AST_NO_NEW_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    (fill >= MAX_PASS && out_pix) |-> dly_p[MAX_PASS-1]); // R1
  AST_ZERO_PASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (fill >= MAX_PASS && out_valid && out_npass == '0) |-> (out_pix == dly_p[MAX_PASS-1])); // R4
  AST_EDGE_WHITE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_npass != '0 && (out_first_row || out_first_col)) |-> !out_pix); // R2
  AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && seen && !(out_first_row && out_first_col)) |-> (out_npass == last_np)); // R6
  AST_RULE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_cnt != '0 && int'(rule_len) > int'(pass_cnt)) |-> (int'(adj_rule) + int'(pass_cnt) + 1 == int'(rule_len))); // R7
  AST_FITS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rule_fits |-> (adj_rule != '0 && int'(adj_rule) <= CHK_MAX)); // R8
  AST_IDLE_WHITE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !out_pix); // R9
endmodule

bind raster_shrink raster_shrink_chk #(
  .MAX_PASS (MAX_PASS),
  .RULE_W   (RULE_W),
  .CHK_MAX  (CHK_MAX)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pass_cnt      (pass_cnt),
  .rule_len      (rule_len),
  .in_valid      (in_valid),
  .in_pix        (in_pix),
  .out_valid     (out_valid),
  .out_pix       (out_pix),
  .adj_rule      (adj_rule),
  .rule_fits     (rule_fits),
  .out_first_row (out_first_row),
  .out_first_col (out_first_col),
  .out_npass     (out_npass)
);

// File: tb/raster_shrink_test.sv
module raster_shrink_test;
  localparam int W  = 16;
  localparam int H  = 12;
  localparam int MP = 7;
  localparam int N  = W * H;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pass_cnt = '0;
  logic [3:0] rule_len = '0;
  logic       in_valid = 1'b0;
  logic       in_pix = 1'b0;
  logic       out_valid, out_pix, rule_fits;
  logic [3:0] adj_rule;

  raster_shrink #(.IMG_W(W), .IMG_H(H), .MAX_PASS(MP)) uut (
    .clk(clk), .rst_n(rst_n), .pass_cnt(pass_cnt), .rule_len(rule_len),
    .in_valid(in_valid), .in_pix(in_pix), .out_valid(out_valid),
    .out_pix(out_pix), .adj_rule(adj_rule), .rule_fits(rule_fits)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  logic img [N];
  logic expv [N];
  logic tmp [N];
  logic rx [N + 8];
  int   rx_n = 0;

  always @(negedge clk) begin
    if (out_valid) begin
      if (rx_n < N + 8) rx[rx_n] = out_pix;
      rx_n++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // direct 2-D erosion: a pixel survives when its 2x2 block ending at it is black
  task automatic make_expected(input int np);
    expv = img;
    for (int k = 0; k < np; k++) begin
      for (int r = 0; r < H; r++)
        for (int c = 0; c < W; c++)
          tmp[r*W+c] = (r > 0 && c > 0) ?
            (expv[r*W+c] & expv[r*W+c-1] & expv[(r-1)*W+c] & expv[(r-1)*W+c-1]) : 1'b0;
      expv = tmp;
    end
  endtask

  function automatic int rule_model(input int m, input int x);
    int v;
    v = (x == 0) ? m : m - x - 1;
    return (v < 0) ? 0 : v;
  endfunction

  task automatic fill_random(input int black_pct);
    for (int i = 0; i < N; i++) img[i] = (($urandom % 100) < black_pct);
  endtask

  task automatic run_frame(input int np, input int np_late, input int gap_pct,
                           input string req);
    int bad;
    int edge_black;
    rx_n = 0;
    for (int i = 0; i < N; i++) begin
      while (gap_pct > 0 && ($urandom % 100) < gap_pct) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_pix   = $urandom % 2;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_pix   = img[i];
      pass_cnt = (i == 0) ? np[2:0] : np_late[2:0];
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_pix   = 1'b0;
    repeat (MP + 3) @(negedge clk);
    make_expected(np);
    check(rx_n == N, "R5", "output pixel count", rx_n, N);
    bad = 0;
    edge_black = 0;
    for (int i = 0; i < N; i++) begin
      if (rx[i] !== expv[i]) bad++;
      if (np > 0 && (i < W || i % W == 0) && rx[i] === 1'b1) edge_black++;
    end
    check(bad == 0, req, $sformatf("mismatching pixels, passes %0d", np), bad, 0);
    if (np > 0) check(edge_black == 0, "R2", "black pixels on frame edge", edge_black, 0);
  endtask

  task automatic rule_case(input int m, input int x);
    int e;
    @(negedge clk);
    rule_len = m[3:0];
    pass_cnt = x[2:0];
    #1;
    e = rule_model(m, x);
    check(int'(adj_rule) == e, "R7", $sformatf("adj_rule m=%0d x=%0d", m, x), adj_rule, e);
    check(rule_fits == (e >= 1 && e <= 4), "R8", "rule_fits", rule_fits, (e >= 1 && e <= 4));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9", "out_valid in reset", out_valid, 0);
    check(out_pix == 1'b0, "R9", "out_pix in reset", out_pix, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 / R4: random frames at every pass count
    for (int np = 0; np <= 7; np++) begin
      fill_random(85);
      run_frame(np, np, 0, (np == 0) ? "R4" : "R3");
    end
    // R1: all-black frame gives an exact staircase, all-white stays white
    for (int i = 0; i < N; i++) img[i] = 1'b1;
    run_frame(3, 3, 0, "R1");
    for (int i = 0; i < N; i++) img[i] = 1'b0;
    run_frame(5, 5, 0, "R1");
    // R5: idle beats inside the frame
    fill_random(85);
    run_frame(2, 2, 30, "R5");
    // R6: count changed after the first pixel is ignored
    fill_random(85);
    run_frame(2, 6, 0, "R6");
    fill_random(85);
    run_frame(0, 4, 10, "R6");

    rule_case(9, 3);
    rule_case(5, 0);
    rule_case(3, 4);
    rule_case(7, 2);
    rule_case(8, 2);
    rule_case(15, 7);
    rule_case(1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule